// File: doc/BRIEF.md
# Phase-Slotted DRAM Address Multiplexer and Refresh Sequencer

This block connects an 8-bit CPU bus with a 16-bit address to a 64K x 8 dynamic memory. The memory is built from two 64K x 4 chips that share one set of address and strobe lines. The block splits each CPU address into two halves:

- the low half is the row, and goes out on an 8-bit multiplexed address port with RAS;
- the high half is the column, and goes out after the row, followed by CAS.

Bus timing comes from two quadrature clocks, E and Q, with Q leading E by a quarter period. The block samples them as ordinary inputs on its fast system clock.

A memory access is confined to the E-high phase:

- RAS falls on the first system clock that sees E high.
- The address switches to the column when Q falls in mid-E-high.
- CAS follows one clock later.
- Every strobe is released on the first clock that sees E low.

For a write, write-enable falls together with the column switch, so the chips see an early write.

Refresh uses the otherwise idle E-low phase. Once every `REFRESH_EVERY` E cycles, the block waits `PRECHARGE_CYC` clocks after E falls. It then runs a RAS-only cycle on the next refresh row, and releases it when Q rises. The CPU is therefore never stalled.

Addresses at or above `ROM_BASE` belong to the ROM and start no DRAM cycle. A read of that region drives the ROM enable low only while E is high, which keeps the ROM off the data bus at all other times.

No part of this interface carries valid/ready handshakes. Every bus cycle is fixed by E, and the memory always keeps pace, so there is no back-pressure to express. All pins are plain control and data levels.

Top module: `dram_addr_ctrl`

## Requirements
- R1: After reset, `dram_ras_n`, `dram_cas_n`, `dram_we_n` and `rom_en_n` are all high (deasserted) and `dram_addr` is zero.
- R2: For an address below `ROM_BASE` (default 0x8000), `dram_ras_n` goes low on the first clock edge that samples E high, and `dram_addr` then carries address bits [7:0].
- R3: During a DRAM access, on the first edge that samples Q low while E is high, `dram_addr` changes to address bits [15:8]. `dram_cas_n` goes low on the next edge.
- R4: On the first edge that samples E low, `dram_ras_n`, `dram_cas_n`, `dram_we_n` and `rom_en_n` all return high.
- R5: On a write (`cpu_rnw` = 0) to the DRAM region, `dram_we_n` goes low on the same edge as the column switch, one clock before CAS. On a read, `dram_we_n` stays high.
- R6: A read (`cpu_rnw` = 1) at or above `ROM_BASE` drives `rom_en_n` low from the first E-high edge until the first E-low edge, with no RAS or CAS. A write to that region leaves every output unchanged.
- R7: On every `REFRESH_EVERY`-th falling edge of E (default 14), a RAS-only refresh runs. `dram_ras_n` goes low `PRECHARGE_CYC` clocks (default 1) after the E-low edge, with CAS and write-enable high. It is released on the first edge that samples Q high.
- R8: The refresh row on `dram_addr` is 0 for the first refresh after reset. It rises by one on each later refresh and wraps from 255 to 0, so all 256 rows are visited.
- R9: `dram_cas_n` and `dram_we_n` are never low while `dram_ras_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than E |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_addr | input | 16 | CPU address, stable through the E cycle |
| cpu_rnw | input | 1 | 1 = read, 0 = write |
| cpu_e | input | 1 | E bus clock; accesses happen while high |
| cpu_q | input | 1 | Q quadrature clock, leads E by a quarter period |
| dram_addr | output | 8 | Multiplexed row/column/refresh address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| rom_en_n | output | 1 | ROM output enable, active low |

## Verification
The sequencer is tried with four access kinds:

- RAM reads, which tell apart the row and column halves and must leave write-enable idle;
- RAM writes, which expose the early-write ordering;
- ROM reads, which isolate the enable window from the DRAM strobes;
- ROM writes, which must produce no activity at all.

Directed addresses sit on both sides of the ROM boundary (0x7FFF and 0x8000), and their row and column bytes differ, so a swapped or stale half shows up. A long run of pseudo-random addresses, with a mix of reads and writes, covers more than 256 refresh slots. That run shows the interval count, the precharge delay and the wrap of the row counter from 255 back to 0.

// File: rtl/dram_mux_pkg.sv
package dram_mux_pkg;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_ROW,
    SEQ_COL,
    SEQ_PRE,
    SEQ_REF
  } seq_state_e;

  typedef struct packed {
    logic e_rise;
    logic e_fall;
    logic q_rise;
    logic q_fall;
  } clk_evt_t;

endpackage

// File: rtl/dram_phase_detect.sv
module dram_phase_detect
  import dram_mux_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     e_in,
  input  logic     q_in,
  output clk_evt_t evt
);

  logic e_d;
  logic q_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_d <= 1'b0;
      q_d <= 1'b0;
    end else begin
      e_d <= e_in;
      q_d <= q_in;
    end
  end

  assign evt.e_rise = e_in & ~e_d;
  assign evt.e_fall = ~e_in & e_d;
  assign evt.q_rise = q_in & ~q_d;
  assign evt.q_fall = ~q_in & q_d;

endmodule

// File: rtl/dram_refresh_ctr.sv
module dram_refresh_ctr #(
  parameter int ROW_W         = 8,
  parameter int REFRESH_EVERY = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             e_fall,
  input  logic             ref_done,
  output logic             ref_due,
  output logic [ROW_W-1:0] ref_row
);

  localparam int CNT_W = (REFRESH_EVERY > 1) ? $clog2(REFRESH_EVERY) : 1;
  localparam logic [CNT_W-1:0] LAST    = CNT_W'(REFRESH_EVERY - 1);
  localparam logic [ROW_W-1:0] ROW_ONE = ROW_W'(1);

  logic [CNT_W-1:0] ecnt;

  assign ref_due = e_fall && (ecnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ecnt <= '0;
    end else if (e_fall) begin
      ecnt <= (ecnt == LAST) ? '0 : ecnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_row <= '0;
    end else if (ref_done) begin
      ref_row <= ref_row + ROW_ONE;
    end
  end

  // R7
  ecnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ecnt <= LAST);

  // R8
  row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_row != $past(ref_row)) |-> (ref_row == $past(ref_row) + ROW_ONE));

endmodule

// File: rtl/dram_access_seq.sv
module dram_access_seq
  import dram_mux_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int ROW_W         = 8,
  parameter int PRECHARGE_CYC = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  clk_evt_t          evt,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rnw,
  input  logic              rom_hit,
  input  logic              ref_due,
  input  logic [ROW_W-1:0]  ref_row,
  output logic              ref_done,
  output logic [ROW_W-1:0]  dram_addr,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic              rom_en_n
);

  localparam int COL_W = ADDR_W - ROW_W;
  localparam int PRE_W = $clog2(PRECHARGE_CYC + 1);
  localparam logic [PRE_W-1:0] PRE_INIT = PRE_W'(PRECHARGE_CYC);
  localparam logic [PRE_W-1:0] PRE_ONE  = PRE_W'(1);

  seq_state_e       state;
  logic [COL_W-1:0] col_lat;
  logic             wr_lat;
  logic [PRE_W-1:0] pre_cnt;

  assign ref_done = (state == SEQ_REF) && (evt.q_rise || evt.e_rise);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= SEQ_IDLE;
      ras_n     <= 1'b1;
      cas_n     <= 1'b1;
      we_n      <= 1'b1;
      dram_addr <= '0;
      col_lat   <= '0;
      wr_lat    <= 1'b0;
      pre_cnt   <= '0;
    end else begin
      unique case (state)
        SEQ_IDLE: begin
          if (evt.e_rise && !rom_hit) begin
            ras_n     <= 1'b0;
            dram_addr <= addr[ROW_W-1:0];
            col_lat   <= addr[ADDR_W-1:ROW_W];
            wr_lat    <= ~rnw;
            state     <= SEQ_ROW;
          end else if (ref_due) begin
            pre_cnt <= PRE_INIT;
            state   <= SEQ_PRE;
          end
        end
        SEQ_ROW, SEQ_COL: begin
          if (evt.e_fall) begin
            ras_n <= 1'b1;
            cas_n <= 1'b1;
            we_n  <= 1'b1;
            if (ref_due) begin
              pre_cnt <= PRE_INIT;
              state   <= SEQ_PRE;
            end else begin
              state <= SEQ_IDLE;
            end
          end else if (state == SEQ_ROW && evt.q_fall) begin
            dram_addr <= ROW_W'(col_lat);
            we_n      <= ~wr_lat;
            state     <= SEQ_COL;
          end else if (state == SEQ_COL) begin
            cas_n <= 1'b0;
          end
        end
        SEQ_PRE: begin
          if (evt.e_rise) begin
            state <= SEQ_IDLE;
          end else if (pre_cnt == PRE_ONE) begin
            ras_n     <= 1'b0;
            dram_addr <= ref_row;
            state     <= SEQ_REF;
          end else begin
            pre_cnt <= pre_cnt - PRE_ONE;
          end
        end
        SEQ_REF: begin
          if (evt.q_rise || evt.e_rise) begin
            ras_n <= 1'b1;
            state <= SEQ_IDLE;
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rom_en_n <= 1'b1;
    end else if (evt.e_rise && rom_hit && rnw) begin
      rom_en_n <= 1'b0;
    end else if (evt.e_fall) begin
      rom_en_n <= 1'b1;
    end
  end

  // R9
  cas_needs_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> !ras_n);

  // R9
  we_needs_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> !ras_n);

  // R3
  cas_after_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> !$past(ras_n));

  // R4
  release_on_e_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt.e_fall |=> (ras_n && cas_n && we_n && rom_en_n));

  // R6
  rom_no_dram_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_en_n |-> (ras_n && cas_n));

  // R6
  rom_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rom_en_n) |-> $past(evt.e_rise));

endmodule

// File: rtl/dram_addr_ctrl.sv
module dram_addr_ctrl
  import dram_mux_pkg::*;
#(
  parameter int                ADDR_W        = 16,
  parameter logic [ADDR_W-1:0] ROM_BASE      = 'h8000,
  parameter int                REFRESH_EVERY = 14,
  parameter int                PRECHARGE_CYC = 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     cpu_addr,
  input  logic                  cpu_rnw,
  input  logic                  cpu_e,
  input  logic                  cpu_q,
  output logic [ADDR_W/2-1:0]   dram_addr,
  output logic                  dram_ras_n,
  output logic                  dram_cas_n,
  output logic                  dram_we_n,
  output logic                  rom_en_n
);

  localparam int ROW_W = ADDR_W / 2;

  clk_evt_t         evt;
  logic             rom_hit;
  logic             ref_due;
  logic             ref_done;
  logic [ROW_W-1:0] ref_row;

  assign rom_hit = (cpu_addr >= ROM_BASE);

  dram_phase_detect i_phase (
    .clk   (clk),
    .rst_n (rst_n),
    .e_in  (cpu_e),
    .q_in  (cpu_q),
    .evt   (evt)
  );

  dram_refresh_ctr #(
    .ROW_W         (ROW_W),
    .REFRESH_EVERY (REFRESH_EVERY)
  ) i_refresh (
    .clk      (clk),
    .rst_n    (rst_n),
    .e_fall   (evt.e_fall),
    .ref_done (ref_done),
    .ref_due  (ref_due),
    .ref_row  (ref_row)
  );

  dram_access_seq #(
    .ADDR_W        (ADDR_W),
    .ROW_W         (ROW_W),
    .PRECHARGE_CYC (PRECHARGE_CYC)
  ) i_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt       (evt),
    .addr      (cpu_addr),
    .rnw       (cpu_rnw),
    .rom_hit   (rom_hit),
    .ref_due   (ref_due),
    .ref_row   (ref_row),
    .ref_done  (ref_done),
    .dram_addr (dram_addr),
    .ras_n     (dram_ras_n),
    .cas_n     (dram_cas_n),
    .we_n      (dram_we_n),
    .rom_en_n  (rom_en_n)
  );

endmodule

// File: tb/test_dram_addr_ctrl.sv
`timescale 1ns/1ps
module test_dram_addr_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        cpu_rnw = 1'b1;
  logic        cpu_e = 1'b0;
  logic        cpu_q = 1'b0;
  logic [7:0]  dram_addr;
  logic        dram_ras_n, dram_cas_n, dram_we_n, rom_en_n;

  always #2.5 clk = ~clk;

  dram_addr_ctrl i_dram_addr_ctrl (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rnw(cpu_rnw),
    .cpu_e(cpu_e), .cpu_q(cpu_q), .dram_addr(dram_addr),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
    .dram_we_n(dram_we_n), .rom_en_n(rom_en_n)
  );

  typedef struct {
    bit       ras;
    bit       cas;
    bit       we;
    bit       rom;
    bit [7:0] addr;
    string    req;
  } exp_t;

  exp_t sb[$];
  exp_t cur;
  int   checks = 0;
  int   failures = 0;
  bit   done = 1'b0;

  int       m_ecnt = 0;
  bit [7:0] m_row = 8'd0;
  bit       m_ref_act = 1'b0;

  // Monitor: compares one expected item per clock, just after the edge.
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t x;
      x = sb.pop_front();
      checks++;
      if (dram_ras_n !== x.ras || dram_cas_n !== x.cas || dram_we_n !== x.we ||
          rom_en_n !== x.rom || dram_addr !== x.addr) begin
        failures++;
        $display("FAIL %s: ras=%b cas=%b we=%b rom=%b addr=%h expected ras=%b cas=%b we=%b rom=%b addr=%h",
                 x.req, dram_ras_n, dram_cas_n, dram_we_n, rom_en_n, dram_addr,
                 x.ras, x.cas, x.we, x.rom, x.addr);
      end
    end
  end

  // Driver: one E cycle of 16 clocks, with Q leading E by 4 clocks.
  task automatic e_cycle(input logic [15:0] a, input logic rnw);
    bit ram    = (a < 16'h8000);
    bit rom_rd = !ram && rnw;
    bit ref_go = 1'b0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      cpu_e = (i >= 4 && i < 12);
      cpu_q = (i < 8);
      if (i == 0) begin
        cpu_addr = a;
        cpu_rnw  = rnw;
      end
      cur.req = ram ? "R9" : "R6";
      if (i == 0 && m_ref_act) begin
        cur.ras = 1'b1;           // R7 refresh released on Q high
        m_row++;
        m_ref_act = 1'b0;
        cur.req = "R7";
      end
      if (i == 4) begin
        if (ram) begin
          cur.ras  = 1'b0;        // R2 row strobe and row half
          cur.addr = a[7:0];
          cur.req  = "R2";
        end else if (rom_rd) begin
          cur.rom = 1'b0;         // R6 ROM enable in E high
          cur.req = "R6";
        end
      end
      if (i == 8 && ram) begin
        cur.addr = a[15:8];       // R3 column half
        cur.we   = rnw;           // R5 early write
        cur.req  = rnw ? "R3" : "R5";
      end
      if (i == 9 && ram) begin
        cur.cas = 1'b0;           // R3 CAS one clock after column
        cur.req = "R3";
      end
      if (i == 12) begin
        cur.ras = 1'b1; cur.cas = 1'b1; cur.we = 1'b1; cur.rom = 1'b1;
        cur.req = "R4";
        if (m_ecnt == 13) begin
          m_ecnt = 0;
          ref_go = 1'b1;
        end else begin
          m_ecnt++;
        end
      end
      if (i == 13 && ref_go) begin
        cur.ras  = 1'b0;          // R8 refresh row sequence
        cur.addr = m_row;
        cur.req  = "R8";
        m_ref_act = 1'b1;
      end
      sb.push_back(cur);
    end
  endtask

  initial begin
    logic [15:0] lf = 16'hACE1;
    cur.ras = 1'b1; cur.cas = 1'b1; cur.we = 1'b1; cur.rom = 1'b1;
    cur.addr = 8'h00; cur.req = "R1";
    repeat (4) @(negedge clk);
    // R1 reset state
    checks++;
    if (dram_ras_n !== 1'b1 || dram_cas_n !== 1'b1 || dram_we_n !== 1'b1 ||
        rom_en_n !== 1'b1 || dram_addr !== 8'h00) begin
      failures++;
      $display("FAIL R1: ras=%b cas=%b we=%b rom=%b addr=%h expected 1 1 1 1 00",
               dram_ras_n, dram_cas_n, dram_we_n, rom_en_n, dram_addr);
    end
    rst_n = 1'b1;
    e_cycle(16'h1234, 1'b1);   // RAM read
    e_cycle(16'h7FAB, 1'b0);   // RAM write
    e_cycle(16'hC001, 1'b1);   // ROM read
    e_cycle(16'h8000, 1'b0);   // ROM write, ignored
    e_cycle(16'h7FFF, 1'b1);   // last RAM address
    e_cycle(16'h8000, 1'b1);   // first ROM address
    for (int n = 0; n < 3614; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      e_cycle(lf, lf[3]);
    end
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #750000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule